// File: doc/BRIEF.md
# Programmable Phase-Accumulator Clock Generator

This block makes a square-wave clock of programmable frequency from a fixed reference clock. An N-bit phase register adds a programmable step word on every enabled reference edge and keeps only the low N bits. Its top bit is the generated clock. The average output frequency is step × Fref / 2^N. For example, with N = 4 and a 16 MHz reference, a step of k gives k MHz.

Edges can only fall on reference ticks. When the step does not divide 2^N evenly, the output period moves between two neighbouring whole-tick lengths, always in a fixed repeating pattern. A step of zero gives a constant level. Steps above half-scale alias, and the block raises a flag for them. An optional toggle stage halves the generated clock. That stage keeps the uneven spacing, because it is driven by the uneven rising edges.

A new step word is taken into a shadow register. It is used from the following reference edge onward. The phase register is never cleared on a reload, so the phase stays continuous. When the enable is low, all state is frozen.

Top module: `nco_clkgen`

## Requirements
- R1: The active-low reset clears the phase register, the step register, the alias flag and the divided clock. While reset is held, `nco_clk_o`, `div2_clk_o` and `alias_o` read 0.
- R2: On each reference edge with `en_i` high, the phase register becomes (phase + step) mod 2^N. `nco_clk_o` equals bit N-1 of the phase register.
- R3: A step that divides 2^N gives evenly spaced rising edges, 2^N/step ticks apart. With N = 4: step 4 gives 4 ticks, step 8 gives 2 ticks and step 1 gives 16 ticks. With N = 20, step 2^16 gives 16 ticks.
- R4: With a step of 0 and `en_i` high, `nco_clk_o` keeps its current level (0 or 1) and makes no rising edge.
- R5: With N = 4, starting from phase 0, the successive rising-edge spacings are 3,3,4,3,3 for step 5; 5,6,5,5,6 for step 3; and 2,2,2,3,2,2,3 for step 7.
- R6: `alias_o` is 1 exactly when the captured step is greater than 2^(N-1). For N = 4: 8 gives 0, 9 and 15 give 1, and 0 gives 0.
- R7: A word presented with `inc_load_i` high is captured on that edge and first added on the next edge. The edge that captures it still adds the old step. A reload does not clear the phase.
- R8: While `en_i` is low, the phase register holds its value and both clock outputs keep their levels. A step load is still captured.
- R9: `div2_clk_o` toggles on exactly those edges where `nco_clk_o` rises. For N = 4 and step 5 from phase 0, its rising-edge spacings are 6,7,6,7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Advance the phase register on this edge |
| inc_load_i | input | 1 | Capture `inc_word_i` into the step register |
| inc_word_i | input | ACC_W | Frequency step word |
| nco_clk_o | output | 1 | Generated clock (phase register top bit) |
| div2_clk_o | output | 1 | Generated clock halved by a toggle stage (0 when DIV2_EN = 0) |
| alias_o | output | 1 | Captured step is above half-scale |

## Verification
The assertions assume that `en_i`, `inc_load_i` and `inc_word_i` change only between reference edges and are never unknown after reset. They also assume that reset is released away from an active edge. The bench drives every input on the falling reference edge and releases reset there. It samples outputs one falling edge after each rising edge, so each observation covers exactly one phase update. Each period-pattern scenario starts from a fresh reset and a load made with the enable low. This fixes the starting phase at zero, which the exact tick patterns depend on.

// File: rtl/nco_pkg.sv
package nco_pkg;
  parameter int unsigned NCO_DEF_W = 20;
endpackage

// File: rtl/nco_inc_reg.sv
module nco_inc_reg #(
  parameter int unsigned INC_W = nco_pkg::NCO_DEF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [INC_W-1:0] word_i,
  output logic [INC_W-1:0] inc_o,
  output logic             alias_o
);
  localparam logic [INC_W-1:0] HALF_SCALE = {1'b1, {(INC_W-1){1'b0}}};

  logic [INC_W-1:0] inc_q;
  logic             alias_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inc_q   <= '0;
      alias_q <= 1'b0;
    end else if (load_i) begin
      inc_q   <= word_i;
      alias_q <= (word_i > HALF_SCALE);
    end
  end

  assign inc_o   = inc_q;
  assign alias_o = alias_q;

  a_r7_capture_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> inc_o == $past(word_i));
  a_r7_keep_without_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(inc_o));
  a_r6_alias_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> alias_o == ($past(word_i) > HALF_SCALE));
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int unsigned ACC_W = nco_pkg::NCO_DEF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [ACC_W-1:0] inc_i,
  output logic             msb_o,
  output logic             msb_nxt_o
);
  localparam int unsigned MSB = ACC_W - 1;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_sum;

  // carry out dropped by width
  assign acc_sum = acc_q + inc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= acc_sum;
  end

  assign msb_o     = acc_q[MSB];
  assign msb_nxt_o = en_i ? acc_sum[MSB] : acc_q[MSB];

  a_r8_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(acc_q));
endmodule

// File: rtl/nco_post_div.sv
module nco_post_div (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic msb_i,
  input  logic msb_nxt_i,
  output logic div_o
);
  logic div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  div_q <= 1'b0;
    else if (!msb_i && msb_nxt_i) div_q <= ~div_q;
  end

  assign div_o = div_q;

  a_r9_toggle_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msb_i) |-> div_q != $past(div_q));
  a_r9_still_otherwise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(msb_i) |-> $stable(div_q));
endmodule

// File: rtl/nco_clkgen.sv
module nco_clkgen #(
  parameter int unsigned ACC_W   = nco_pkg::NCO_DEF_W,
  parameter bit          DIV2_EN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             inc_load_i,
  input  logic [ACC_W-1:0] inc_word_i,
  output logic             nco_clk_o,
  output logic             div2_clk_o,
  output logic             alias_o
);
  logic [ACC_W-1:0] inc_q;
  logic             msb, msb_nxt;

  nco_inc_reg #(.INC_W(ACC_W)) u_inc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (inc_load_i),
    .word_i  (inc_word_i),
    .inc_o   (inc_q),
    .alias_o (alias_o)
  );

  nco_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .inc_i     (inc_q),
    .msb_o     (msb),
    .msb_nxt_o (msb_nxt)
  );

  assign nco_clk_o = msb;

  generate
    if (DIV2_EN) begin : g_div2
      nco_post_div u_div (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .msb_i     (msb),
        .msb_nxt_i (msb_nxt),
        .div_o     (div2_clk_o)
      );
    end else begin : g_no_div2
      assign div2_clk_o = 1'b0;
    end
  endgenerate

  a_r4_dc_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && inc_q == '0) |=> $stable(nco_clk_o));
  a_r8_outputs_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(nco_clk_o) && $stable(div2_clk_o)));
endmodule

// File: tb/nco_clkgen_bench.sv
module nco_clkgen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       en = 1'b0, ld = 1'b0;
  logic [3:0] word = '0;
  logic       nco, div, als;

  logic        wen = 1'b0, wld = 1'b0;
  logic [19:0] wword = '0;
  logic        wnco, wdiv, wals;

  nco_clkgen #(.ACC_W(4)) u_nco_clkgen (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .inc_load_i(ld), .inc_word_i(word),
    .nco_clk_o(nco), .div2_clk_o(div), .alias_o(als));

  nco_clkgen #(.ACC_W(20)) u_nco_clkgen_wide (
    .clk_i(clk), .rst_ni(rst_n), .en_i(wen), .inc_load_i(wld), .inc_word_i(wword),
    .nco_clk_o(wnco), .div2_clk_o(wdiv), .alias_o(wals));

  int n_chk = 0, n_fail = 0;
  logic [3:0] m_acc, m_inc;
  logic m_div, m_alias;
  int edge_idx, n_rise, n_drise;
  int rise_at[16];
  int drise_at[16];
  logic prev_nco, prev_div;

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst_n = 1'b0; en = 0; ld = 0; wen = 0; wld = 0;
    m_acc = '0; m_inc = '0; m_div = 0; m_alias = 0;
    @(negedge clk);
    chk(nco, 0, {tag, " R1 nco"});
    chk(div, 0, {tag, " R1 div"});
    chk(als, 0, {tag, " R1 alias"});
    chk(wnco, 0, {tag, " R1 wide nco"});
    chk(wals, 0, {tag, " R1 wide alias"});
    rst_n = 1'b1;
    edge_idx = 0; n_rise = 0; n_drise = 0; prev_nco = 0; prev_div = 0;
  endtask

  // drive at a falling edge, model the next rising edge, compare at the next falling edge
  task automatic step(input logic l, input logic [3:0] w, input logic e, input string tag);
    logic [3:0] nx;
    ld = l; word = w; en = e;
    if (e) begin
      nx = m_acc + m_inc;
      if (!m_acc[3] && nx[3]) m_div = ~m_div;
      m_acc = nx;
    end
    if (l) begin
      m_inc = w;
      m_alias = (w > 4'd8);
    end
    @(negedge clk);
    chk(nco, m_acc[3], {tag, " nco"});
    chk(div, m_div, {tag, " div"});
    chk(als, m_alias, {tag, " alias"});
    edge_idx++;
    if (!prev_nco && nco) begin
      if (n_rise < 16) rise_at[n_rise] = edge_idx;
      n_rise++;
    end
    if (!prev_div && div) begin
      if (n_drise < 16) drise_at[n_drise] = edge_idx;
      n_drise++;
    end
    prev_nco = nco;
    prev_div = div;
  endtask

  task automatic run_pattern(input logic [3:0] inc, input int n, input int exp[8],
                             input int steps, input string tag);
    do_reset(tag);
    step(1'b1, inc, 1'b0, tag);
    edge_idx = 0; n_rise = 0; n_drise = 0;
    for (int i = 0; i < steps; i++) step(1'b0, 4'd0, 1'b1, tag);
    chk(n_rise >= n + 1, 1, {tag, " rise count"});
    for (int i = 0; i < n && i < 15; i++)
      chk(rise_at[i+1] - rise_at[i], exp[i], {tag, " spacing"});
  endtask

  task automatic t_reset_r1;
    do_reset("R1 initial");
    step(1'b1, 4'd11, 1'b0, "R1 load");
    for (int i = 0; i < 5; i++) step(1'b0, 4'd0, 1'b1, "R1 run");
    do_reset("R1 after activity");
  endtask

  task automatic t_wrap_r2;
    do_reset("R2");
    step(1'b1, 4'd11, 1'b0, "R2 load");
    for (int i = 0; i < 20; i++) step(1'b0, 4'd0, 1'b1, "R2 step 11");
    step(1'b1, 4'd15, 1'b1, "R2 reload 15");
    for (int i = 0; i < 20; i++) step(1'b0, 4'd0, 1'b1, "R2 step 15");
  endtask

  task automatic t_rate_r3;
    logic [19:0] wacc;
    int wr[4];
    int wn;
    run_pattern(4'd4, 3, '{4, 4, 4, 0, 0, 0, 0, 0}, 24, "R3 step4");
    run_pattern(4'd8, 3, '{2, 2, 2, 0, 0, 0, 0, 0}, 12, "R3 step8");
    run_pattern(4'd1, 2, '{16, 16, 0, 0, 0, 0, 0, 0}, 48, "R3 step1");
    do_reset("R3 wide");
    wld = 1'b1; wword = 20'h10000;
    @(negedge clk);
    wld = 1'b0; wen = 1'b1;
    wn = 0; wacc = '0;
    for (int k = 1; k <= 64; k++) begin
      logic pv;
      pv = wnco;
      @(negedge clk);
      if (!pv && wnco && wn < 4) begin wr[wn] = k; wn++; end
    end
    wen = 1'b0;
    chk(wn, 4, "R3 wide rise count");
    chk(wr[1] - wr[0], 16, "R3 wide spacing");
    chk(wr[3] - wr[2], 16, "R3 wide spacing");
    chk(wals, 0, "R6 wide step 2^16 alias");
    chk(int'(wacc), 0, "R3 wide bench sanity");
  endtask

  task automatic t_dc_r4;
    do_reset("R4 low");
    step(1'b1, 4'd0, 1'b0, "R4 load zero");
    for (int i = 0; i < 40; i++) step(1'b0, 4'd0, 1'b1, "R4 low run");
    chk(n_rise, 0, "R4 no rise at low DC");
    chk(nco, 0, "R4 low level");
    do_reset("R4 high");
    step(1'b1, 4'd8, 1'b0, "R4 load 8");
    step(1'b0, 4'd0, 1'b1, "R4 reach high");
    step(1'b1, 4'd0, 1'b0, "R4 load zero");
    n_rise = 0;
    for (int i = 0; i < 20; i++) step(1'b0, 4'd0, 1'b1, "R4 high run");
    chk(n_rise, 0, "R4 no rise at high DC");
    chk(nco, 1, "R4 high level");
  endtask

  task automatic t_patterns_r5;
    run_pattern(4'd5, 5, '{3, 3, 4, 3, 3, 0, 0, 0}, 40, "R5 step5");
    run_pattern(4'd3, 5, '{5, 6, 5, 5, 6, 0, 0, 0}, 40, "R5 step3");
    run_pattern(4'd7, 7, '{2, 2, 2, 3, 2, 2, 3, 0}, 40, "R5 step7");
  endtask

  task automatic t_alias_r6;
    do_reset("R6");
    step(1'b1, 4'd8, 1'b0, "R6 load 8");  chk(als, 0, "R6 step 8");
    step(1'b1, 4'd9, 1'b0, "R6 load 9");  chk(als, 1, "R6 step 9");
    step(1'b1, 4'd15, 1'b0, "R6 load 15"); chk(als, 1, "R6 step 15");
    step(1'b1, 4'd0, 1'b0, "R6 load 0");  chk(als, 0, "R6 step 0");
    @(negedge clk);
    wld = 1'b1; wword = 20'h80000;
    @(negedge clk);
    chk(wals, 0, "R6 wide half-scale");
    wword = 20'h80001;
    @(negedge clk);
    chk(wals, 1, "R6 wide above half-scale");
    wld = 1'b0;
  endtask

  task automatic t_reload_r7;
    do_reset("R7");
    step(1'b1, 4'd4, 1'b0, "R7 load 4");
    for (int i = 0; i < 3; i++) step(1'b0, 4'd0, 1'b1, "R7 run 4");
    chk(nco, 1, "R7 phase 12 high");
    step(1'b1, 4'd1, 1'b1, "R7 reload 1");
    chk(nco, 0, "R7 old step used on capture edge");
    for (int i = 0; i < 7; i++) step(1'b0, 4'd0, 1'b1, "R7 run 1");
    chk(nco, 0, "R7 phase 7 low, not cleared");
    step(1'b0, 4'd0, 1'b1, "R7 run 1");
    chk(nco, 1, "R7 phase 8 high");
  endtask

  task automatic t_enable_r8;
    do_reset("R8");
    step(1'b1, 4'd5, 1'b0, "R8 load 5");
    for (int i = 0; i < 6; i++) step(1'b0, 4'd0, 1'b1, "R8 run");
    chk(nco, 1, "R8 level before hold");
    for (int i = 0; i < 10; i++) begin
      step(1'b0, 4'd0, 1'b0, "R8 hold");
      chk(nco, 1, "R8 nco frozen");
    end
    step(1'b1, 4'd3, 1'b0, "R8 load while held");
    chk(nco, 1, "R8 nco frozen on load");
    for (int i = 0; i < 12; i++) step(1'b0, 4'd0, 1'b1, "R8 resume");
  endtask

  task automatic t_div_r9;
    run_pattern(4'd5, 5, '{3, 3, 4, 3, 3, 0, 0, 0}, 40, "R9 step5");
    chk(n_drise >= 5, 1, "R9 div rise count");
    chk(drise_at[1] - drise_at[0], 6, "R9 div spacing");
    chk(drise_at[2] - drise_at[1], 7, "R9 div spacing");
    chk(drise_at[3] - drise_at[2], 6, "R9 div spacing");
    chk(drise_at[4] - drise_at[3], 7, "R9 div spacing");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset_r1();
    t_wrap_r2();
    t_rate_r3();
    t_dc_r4();
    t_patterns_r5();
    t_alias_r6();
    t_reload_r7();
    t_enable_r8();
    t_div_r9();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule